// File: doc/BRIEF.md
# Scancode-to-Button Event Decoder

This block turns a stream of 8-bit keyboard scancodes into front-panel button and rotary-wheel bits inside a 32-bit input-state word. A code is accepted on a clock edge when `codeValid` is high. Bit 7 of the code marks a key going down, and bits [6:0] name the key. A single prefix byte (default 0xE0) selects a second key table, and that selection lasts for exactly one following code.

On a press, the bits that belong to the key are ORed into the state word. On a release, the key's bits are cleared. A one-cycle interrupt pulse is raised only if at least one of those bits was set just before the release. A press never raises the interrupt. Keys that are not in the active table leave the state word and the interrupt untouched. The block is meant to sit between a keyboard byte receiver and an interrupt controller, so that software reading the state word sees the panel as if it were wired to the buttons directly.

Top module: `scan_button_decoder`

## Requirements
- R1: After reset, `btnState` is 0, `evtIrq` is 0, and the prefix selection is inactive.
- R2: An accepted code equal to the prefix value (0xE0) makes the next code use the wheel table. It does not change `btnState` and raises no interrupt.
- R3: The prefix selection ends once the next accepted code that is not the prefix has been processed. Repeated prefix codes keep it active.
- R4: The wheel table (prefix active) maps key 0x48 to bits 11 and 10, key 0x50 to bit 10, key 0x4B to bits 9 and 8, and key 0x4D to bit 8.
- R5: The button table (prefix inactive) maps key 0x21 to bit 19, key 0x32 to bit 20, key 0x0F to bit 21, and key 0x1C to bit 22.
- R6: A code with bit 7 set ORs the key's bits into `btnState` one cycle later. All other bits are kept, and no interrupt is raised, even when the bits were already set.
- R7: A code with bit 7 clear whose key bits overlap `btnState` clears those bits and drives `evtIrq` high for the following cycle only.
- R8: A release whose key bits are all clear leaves `btnState` unchanged and raises no interrupt.
- R9: A key with no entry in the active table has an empty bit mask. It changes neither `btnState` nor `evtIrq`, and this includes a button key sent after the prefix.
- R10: While `codeValid` is low, `scanCode` is ignored. The state word, the interrupt and the prefix selection all hold.
- R11: A release whose key bits are only partly set clears all of that key's bits and raises the interrupt.
- R12: Releases in back-to-back cycles that each hit set bits give interrupt pulses in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| codeValid | input | 1 | Qualifies `scanCode` for this cycle |
| scanCode | input | 8 | Scancode: bit 7 = pressed, bits [6:0] = key |
| btnState | output | 32 | Button and wheel input-state word |
| evtIrq | output | 1 | One-cycle pulse on a release that cleared bits |

## Verification
The bench builds the block with its default prefix value of 0xE0, which is the only parameter that changes behaviour. With that value, every entry of both tables can be reached, and so can a button key placed behind the prefix and a wheel key sent without it. The stimulus sets up the state word so that releases fall onto fully set, partly set and fully clear bits. It also sends releases in consecutive cycles, so that the interrupt can be seen as adjacent pulses rather than one merged level.

// File: rtl/scan_button_pkg.sv
package scan_button_pkg;

  localparam int unsigned CODE_W  = 8;
  localparam int unsigned KEY_W   = CODE_W - 1;
  localparam int unsigned STATE_W = 32;

  // bit positions in the state word (decoded by software)
  localparam int unsigned POS_VOL_STEP = 8;
  localparam int unsigned POS_VOL_DIR  = 9;
  localparam int unsigned POS_NAV_STEP = 10;
  localparam int unsigned POS_NAV_DIR  = 11;
  localparam int unsigned POS_BTN_FAV  = 19;
  localparam int unsigned POS_BTN_MENU = 20;
  localparam int unsigned POS_BTN_VOL  = 21;
  localparam int unsigned POS_BTN_NAV  = 22;

  // key identifiers (code bits [6:0])
  localparam logic [KEY_W-1:0] KEY_ARROW_UP    = 7'h48;
  localparam logic [KEY_W-1:0] KEY_ARROW_DOWN  = 7'h50;
  localparam logic [KEY_W-1:0] KEY_ARROW_LEFT  = 7'h4B;
  localparam logic [KEY_W-1:0] KEY_ARROW_RIGHT = 7'h4D;
  localparam logic [KEY_W-1:0] KEY_LETTER_F    = 7'h21;
  localparam logic [KEY_W-1:0] KEY_LETTER_M    = 7'h32;
  localparam logic [KEY_W-1:0] KEY_TAB         = 7'h0F;
  localparam logic [KEY_W-1:0] KEY_RETURN      = 7'h1C;

  typedef logic [STATE_W-1:0] stateWord_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       doSet;
    logic       doRelease;
    stateWord_t mask;
  } evtCmd_t;

  function automatic stateWord_t bitOf(input int unsigned pos);
    stateWord_t w;
    w = '0;
    w[pos] = 1'b1;
    return w;
  endfunction

  function automatic stateWord_t wheelMask(input logic [KEY_W-1:0] key);
    stateWord_t m;
    unique case (key)
      KEY_ARROW_UP:    m = bitOf(POS_NAV_STEP) | bitOf(POS_NAV_DIR);
      KEY_ARROW_DOWN:  m = bitOf(POS_NAV_STEP);
      KEY_ARROW_LEFT:  m = bitOf(POS_VOL_STEP) | bitOf(POS_VOL_DIR);
      KEY_ARROW_RIGHT: m = bitOf(POS_VOL_STEP);
      default:         m = '0;
    endcase
    return m;
  endfunction

  function automatic stateWord_t buttonMask(input logic [KEY_W-1:0] key);
    stateWord_t m;
    unique case (key)
      KEY_LETTER_F: m = bitOf(POS_BTN_FAV);
      KEY_LETTER_M: m = bitOf(POS_BTN_MENU);
      KEY_TAB:      m = bitOf(POS_BTN_VOL);
      KEY_RETURN:   m = bitOf(POS_BTN_NAV);
      default:      m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/scan_button_ctrl.sv
module scan_button_ctrl
  import scan_button_pkg::*;
#(
  parameter logic [CODE_W-1:0] PREFIX_CODE = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              codeValid,
  input  logic [CODE_W-1:0] scanCode,
  output evtCmd_t           cmd
);

  logic             extFlag;
  logic             isPrefix;
  logic             takeKey;
  logic             pressed;
  logic [KEY_W-1:0] keyId;
  stateWord_t       wheelM;
  stateWord_t       buttonM;
  stateWord_t       keyMask;
  logic             maskHit;

  assign isPrefix = codeValid && (scanCode == PREFIX_CODE);
  assign takeKey  = codeValid && !isPrefix;
  assign pressed  = scanCode[CODE_W-1];
  assign keyId    = scanCode[KEY_W-1:0];

  always_comb begin
    wheelM  = wheelMask(keyId);
    buttonM = buttonMask(keyId);
    keyMask = extFlag ? wheelM : buttonM;
  end

  assign maskHit = |keyMask;

  // prefix selection: armed by prefix, dropped by any other accepted code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      extFlag <= 1'b0;
    end else if (isPrefix) begin
      extFlag <= 1'b1;
    end else if (takeKey) begin
      extFlag <= 1'b0;
    end
  end

  always_comb begin
    cmd.doSet     = takeKey && pressed && maskHit;
    cmd.doRelease = takeKey && !pressed && maskHit;
    cmd.mask      = keyMask;
  end

  // R2: a prefix code issues no strobe
  a_r2_prefix_silent: assert property (@(posedge clk) disable iff (!rst_n)
    isPrefix |-> !(cmd.doSet || cmd.doRelease));

  // R3: selection ends after the next non-prefix code
  a_r3_prefix_drops: assert property (@(posedge clk) disable iff (!rst_n)
    takeKey |=> !extFlag);

  // R10: idle cycles keep the selection
  a_r10_idle_holds_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    !codeValid |=> $stable(extFlag));

  // R9: strobes only carry a non-empty mask
  a_r9_strobe_has_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.doSet || cmd.doRelease) |-> (cmd.mask != '0));

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.doSet && cmd.doRelease));

endmodule

// File: rtl/scan_button_dp.sv
module scan_button_dp
  import scan_button_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  evtCmd_t    cmd,
  output stateWord_t btnState,
  output logic       evtIrq
);

  stateWord_t stateQ;
  stateWord_t stateD;
  logic       overlap;
  logic       irqQ;

  assign overlap = |(stateQ & cmd.mask);

  always_comb begin
    stateD = stateQ;
    if (cmd.doSet) begin
      stateD = stateQ | cmd.mask;
    end else if (cmd.doRelease && overlap) begin
      stateD = stateQ & ~cmd.mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= '0;
      irqQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      irqQ   <= cmd.doRelease && overlap;
    end
  end

  assign btnState = stateQ;
  assign evtIrq   = irqQ;

  // R6: a press leaves every mask bit set and raises nothing
  a_r6_press_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.doSet |=> (((stateQ & $past(cmd.mask)) == $past(cmd.mask)) && !irqQ));

  // R7: a hitting release clears the mask bits and pulses
  a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.doRelease && overlap) |=> (((stateQ & $past(cmd.mask)) == '0) && irqQ));

  // R8: a missing release changes nothing
  a_r8_release_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.doRelease && !overlap) |=> ($stable(stateQ) && !irqQ));

  // R10: no strobe, no change
  a_r10_no_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.doSet || cmd.doRelease) |=> ($stable(stateQ) && !irqQ));

endmodule

// File: rtl/scan_button_decoder.sv
module scan_button_decoder
  import scan_button_pkg::*;
#(
  parameter logic [7:0] PREFIX_CODE = 8'hE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        codeValid,
  input  logic [7:0]  scanCode,
  output logic [31:0] btnState,
  output logic        evtIrq
);

  evtCmd_t cmd;

  scan_button_ctrl #(
    .PREFIX_CODE(PREFIX_CODE)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .codeValid(codeValid),
    .scanCode (scanCode),
    .cmd      (cmd)
  );

  scan_button_dp i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .btnState(btnState),
    .evtIrq  (evtIrq)
  );

endmodule

// File: tb/test_scan_button_decoder.sv
module test_scan_button_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        codeValid = 1'b0;
  logic [7:0]  scanCode = 8'h00;
  logic [31:0] btnState;
  logic        evtIrq;

  int unsigned errors = 0;
  int unsigned checks = 0;
  int unsigned cyc = 0;
  bit          finished = 0;

  typedef struct {
    int unsigned due;
    logic [31:0] st;
    logic        irq;
    string       tag;
  } expItem_t;

  expItem_t    sb[$];
  logic [31:0] modelState = '0;
  bit          modelExt = 0;

  scan_button_decoder i_scan_button_decoder (
    .clk      (clk),
    .rst_n    (rst_n),
    .codeValid(codeValid),
    .scanCode (scanCode),
    .btnState (btnState),
    .evtIrq   (evtIrq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] refMask(bit ext, logic [6:0] k);
    logic [31:0] m = '0;
    if (ext) begin
      if (k == 7'h48) m = 32'h0000_0C00;
      if (k == 7'h50) m = 32'h0000_0400;
      if (k == 7'h4B) m = 32'h0000_0300;
      if (k == 7'h4D) m = 32'h0000_0100;
    end else begin
      if (k == 7'h21) m = 32'h0008_0000;
      if (k == 7'h32) m = 32'h0010_0000;
      if (k == 7'h0F) m = 32'h0020_0000;
      if (k == 7'h1C) m = 32'h0040_0000;
    end
    return m;
  endfunction

  task automatic compare(string tag, logic [31:0] st, logic irq);
    checks++;
    if (btnState !== st || evtIrq !== irq) begin
      errors++;
      $display("FAIL %s: state=%h irq=%b expected state=%h irq=%b",
               tag, btnState, evtIrq, st, irq);
    end
  endtask

  // monitor: pop items due in this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      expItem_t e;
      e = sb.pop_front();
      compare(e.tag, e.st, e.irq);
    end
  end

  // driver: one code per call, called at a falling edge
  task automatic sendCode(logic [7:0] c, string tag);
    expItem_t e;
    logic [31:0] m;
    bit irq = 0;
    codeValid = 1'b1;
    scanCode  = c;
    if (c == 8'hE0) begin
      modelExt = 1;
    end else begin
      m = refMask(modelExt, c[6:0]);
      if (c[7]) modelState = modelState | m;
      else if ((modelState & m) != 0) begin
        modelState = modelState & ~m;
        irq = 1;
      end
      modelExt = 0;
    end
    e.due = cyc + 1; e.st = modelState; e.irq = irq; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(logic [7:0] c, string tag);
    expItem_t e;
    codeValid = 1'b0;
    scanCode  = c;
    e.due = cyc + 1; e.st = modelState; e.irq = 0; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 reset in", 32'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset", 32'h0, 1'b0);

    sendCode(8'hE0, "R2 prefix no effect");
    sendCode(8'hC8, "R4 up press");
    sendCode(8'hA1, "R3 prefix dropped, F press");
    sendCode(8'hE0, "R2 prefix");
    sendCode(8'hA1, "R9 button key behind prefix");
    sendCode(8'hA1, "R6 repeat press");
    sendCode(8'h8F, "R5 tab press");
    sendCode(8'h9C, "R5 return press");
    sendCode(8'hB2, "R5 M press");
    sendCode(8'hC8, "R9 wheel key without prefix");
    sendCode(8'hE0, "R2 prefix");
    sendCode(8'hCB, "R4 left press");
    sendCode(8'hE0, "R2 prefix");
    sendCode(8'hD0, "R4 down press");
    sendCode(8'hE0, "R2 prefix");
    sendCode(8'hCD, "R4 right press");
    sendCode(8'hE0, "R2 prefix");
    sendCode(8'h50, "R7 down release");
    idle(8'h00, "R7 pulse ends");
    sendCode(8'hE0, "R2 prefix");
    sendCode(8'h48, "R11 up release partly set");
    sendCode(8'hE0, "R2 prefix");
    sendCode(8'h48, "R8 up release all clear");
    sendCode(8'h0F, "R7 tab release");
    sendCode(8'h32, "R12 M release back to back");
    sendCode(8'h1C, "R12 return release back to back");
    idle(8'h00, "R7 pulse ends");
    sendCode(8'h95, "R9 unmapped press");
    sendCode(8'h15, "R9 unmapped release");
    idle(8'h32, "R10 ignored release code");
    idle(8'hE0, "R10 ignored prefix code");
    sendCode(8'hC8, "R10 prefix not armed while idle");
    sendCode(8'hE0, "R3 first prefix");
    idle(8'hA1, "R10 idle keeps prefix");
    sendCode(8'hE0, "R3 repeated prefix");
    sendCode(8'hC8, "R3 R4 up after double prefix");
    sendCode(8'hE0, "R2 prefix");
    sendCode(8'h4B, "R7 left release");
    sendCode(8'hE0, "R2 prefix");
    sendCode(8'h4D, "R8 right release all clear");
    sendCode(8'h21, "R7 F release");
    sendCode(8'h21, "R8 F release again");
    idle(8'h00, "R7 final idle");
    repeat (2) @(negedge clk);
    summary();
  end

endmodule